// File: doc/BRIEF.md
# Event Interrupt Enable and Status Unit

This unit is the device-side interrupt logic of a memory-mapped command and response module. Four event sources (data available, status valid, locality change and command ready) arrive as single-cycle pulses. Each event is recorded in a status register if that source is enabled. The unit drives one interrupt line whose trigger type and polarity are chosen by software.

Software programs the unit through a simple word-addressed register bus. There are four words: an enable word holding a global gate, per-source enables and a 2-bit trigger type; a status word that software clears by writing ones; an 8-bit vector word of which only the low nibble is stored; and a constant capability word. A handler reads the status word and writes the same value back to acknowledge. An event that arrives in the same cycle as that write is not lost.

Read data is registered: `rdata` shows the word selected by `addr` one clock edge later. The interrupt output is also registered.

Top module: `evirq_unit`

## Requirements
- R1: After synchronous reset, the enable, status and vector words read 0 and `irq_out` is 0.
- R2: The enable word (addr 0) keeps only bit 31 (global enable), bits 4:3 (trigger type) and the per-source bits 0, 1, 2 and 7. All other bits read 0, so writing all ones reads back 0x8000009F.
- R3: A source pulse on `evt[i]` sets its status bit only while that source's enable bit is 1. The mapping of `evt[0..3]` to enable and status bit positions is 0, 1, 2, 7. A pulse from a disabled source leaves the status word unchanged.
- R4: Writing the status word (addr 1) clears every implemented bit written as 1. Bits written as 0 are left unchanged.
- R5: If a source pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: While enable bit 31 is 0, `irq_out` rests at the inactive level of the selected type: 0 for types 00 and 10, 1 for types 01 and 11. This holds even with pending status.
- R7: Type 00 (level high): `irq_out` is 1 while any status bit is set and its source enable is 1, with the global enable on. It is 0 once no such pair remains, including when only the source enable is removed.
- R8: Type 01 (level low): `irq_out` is the inverse of the R7 behaviour, so it is 0 while an enabled interrupt is pending and 1 otherwise.
- R9: Type 10 (rising edge): `irq_out` rests at 0. It goes high for exactly one cycle when the pending condition changes from false to true, and a further event while the condition is still true gives no new pulse.
- R10: Type 11 (falling edge): `irq_out` rests at 1 and goes low for exactly one cycle on each false-to-true change of the pending condition.
- R11: The vector word (addr 2) stores the low 4 bits of the write data. Bits 31:4 read 0.
- R12: The capability word (addr 3) always reads 0x000000FF, and writes to it have no effect.
- R13: Status bits other than 0, 1, 2 and 7 read 0. With all four sources enabled and pulsed together, the status word reads 0x87.
- R14: `irq_out` changes one clock edge after the status or enable register it depends on changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word select: 0 enable, 1 status, 2 vector, 3 capability |
| wdata | input | 32 | Write data |
| evt | input | 4 | Single-cycle source pulses: data available, status valid, locality change, command ready |
| rdata | output | 32 | Registered read data of the word selected by `addr` one edge earlier |
| irq_out | output | 1 | Interrupt line, shaped by the trigger type |

## Verification
The line is tried in all four trigger types with the same single-source pulse. This separates the level types, where the output follows pending status until it is cleared, from the edge types, which give a one-cycle pulse and then stay silent on a repeated event. The global gate and the per-source mask are each removed while status is pending, which shows that either one alone suppresses the line. A pulse that meets a clearing write in the same cycle shows that set wins over clear. A pulse from a disabled source shows that it is never recorded. Pulsing all sources at once and writing all ones to every word exposes the bit positions that are stored and the ones that read back 0.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_e;

  localparam int SRC_N = 4;
  localparam int DATA_W = 32;
  // bit position of each source in the enable and status words
  localparam int SRC_POS [SRC_N] = '{0, 1, 2, 7};
  localparam int GLB_POS = 31;
  localparam int TRIG_LSB = 3;

  localparam logic [DATA_W-1:0] ENA_MASK  = 32'h8000_009F;
  localparam logic [DATA_W-1:0] CAP_VALUE = 32'h0000_00FF;

  localparam logic [1:0] SEL_ENA = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_VEC = 2'd2;
  localparam logic [1:0] SEL_CAP = 2'd3;
endpackage

// File: rtl/evirq_ctrl_regs.sv
module evirq_ctrl_regs
  import evirq_pkg::*;
#(
  parameter int VEC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena_we,
  input  logic              vec_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ena_q,
  output logic [VEC_W-1:0]  vec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
      vec_q <= '0;
    end else begin
      if (ena_we) ena_q <= wdata & ENA_MASK;
      if (vec_we) vec_q <= wdata[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/evirq_status.sv
module evirq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] src_en,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] sts_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                       sts_q[i] <= 1'b0;
      else if (evt[i] && src_en[i])  sts_q[i] <= 1'b1;  // set has priority
      else if (clr_we && clr_bits[i]) sts_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evirq_shaper.sv
module evirq_shaper
  import evirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pend,
  input  trig_e mode,
  output logic  irq_q
);
  logic pend_q;
  logic edge_mode;
  logic active;

  always_comb begin
    edge_mode = mode[1];
    active    = edge_mode ? (pend & ~pend_q) : pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend;
      irq_q  <= active ^ mode[0];  // mode[0] selects the low-active polarity
    end
  end
endmodule

// File: rtl/evirq_unit.sv
module evirq_unit
  import evirq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int VEC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_N-1:0]  evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);
  logic [DATA_W-1:0] ena_q;
  logic [VEC_W-1:0]  vec_q;
  logic [SRC_N-1:0]  sts_q;
  logic [SRC_N-1:0]  src_en;
  logic [SRC_N-1:0]  clr_bits;
  logic [DATA_W-1:0] sts_word;
  logic              pend;

  for (genvar i = 0; i < SRC_N; i++) begin : g_map
    assign src_en[i]   = ena_q[SRC_POS[i]];
    assign clr_bits[i] = wdata[SRC_POS[i]];
  end

  always_comb begin
    sts_word = '0;
    for (int i = 0; i < SRC_N; i++) sts_word[SRC_POS[i]] = sts_q[i];
    pend = ena_q[GLB_POS] && |(sts_q & src_en);
  end

  evirq_ctrl_regs #(.VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst),
    .ena_we(wr_en && addr == ADDR_W'(SEL_ENA)),
    .vec_we(wr_en && addr == ADDR_W'(SEL_VEC)),
    .wdata(wdata), .ena_q(ena_q), .vec_q(vec_q)
  );

  evirq_status #(.N(SRC_N)) u_sts (
    .clk(clk), .rst(rst), .evt(evt), .src_en(src_en),
    .clr_we(wr_en && addr == ADDR_W'(SEL_STS)),
    .clr_bits(clr_bits), .sts_q(sts_q)
  );

  evirq_shaper u_shape (
    .clk(clk), .rst(rst), .pend(pend),
    .mode(trig_e'(ena_q[TRIG_LSB+1:TRIG_LSB])),
    .irq_q(irq_out)
  );

  always_ff @(posedge clk) begin
    case (addr)
      ADDR_W'(SEL_ENA): rdata <= ena_q;
      ADDR_W'(SEL_STS): rdata <= sts_word;
      ADDR_W'(SEL_VEC): rdata <= DATA_W'(vec_q);
      default:          rdata <= CAP_VALUE;
    endcase
  end
endmodule

// File: rtl/evirq_unit_chk.sv
module evirq_unit_chk
  import evirq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              clr0,
  input logic              evt0,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_out,
  input logic              glb,
  input logic              en0,
  input logic              en7,
  input logic [1:0]        mode,
  input logic              sts0,
  input logic              sts7
);
  // R3: a disabled source never sets its status bit
  p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    (!en7 && !sts7) |=> !sts7);

  // R4: a one written to the status word clears the bit unless a set collides
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(SEL_STS) && clr0 && !(evt0 && en0)) |=> !sts0);

  // R6: global enable off keeps the line at the type's inactive level
  p_glb_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!glb) |=> (irq_out == $past(mode[0])));

  // R9: rising-edge pulse lasts one cycle
  p_rise_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && irq_out && !(wr_en && addr == ADDR_W'(SEL_ENA))) |=> !irq_out);

  // R12: capability word is constant
  p_cap_const_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(SEL_CAP)) |-> (rdata == CAP_VALUE));
endmodule

bind evirq_unit evirq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .clr0(wdata[0]),
  .evt0(evt[0]), .rdata(rdata), .irq_out(irq_out),
  .glb(ena_q[31]), .en0(ena_q[0]), .en7(ena_q[7]), .mode(ena_q[4:3]),
  .sts0(sts_q[0]), .sts7(sts_q[3])
);

// File: tb/evirq_unit_bench.sv
module evirq_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [3:0]  evt;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic rd_issue = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [1:0] A_ENA = 2'd0, A_STS = 2'd1, A_VEC = 2'd2, A_CAP = 2'd3;

  always #2 clk = ~clk;  // 250 MHz

  evirq_unit u_evirq_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .evt(evt), .rdata(rdata), .irq_out(irq_out)
  );

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) begin
    exp_t e;
    if (rd_issue) begin
      #1;
      e = sb_q.pop_front();
      checks++;
      if (rdata !== e.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", e.tag, rdata, e.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    addr = a; rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out=%b expected=%b", tag, irq_out, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk_irq(1'b0, "R1 reset irq");
    rd(A_ENA, 32'h0, "R1 reset enable");
    rd(A_STS, 32'h0, "R1 reset status");
    rd(A_VEC, 32'h0, "R1 reset vector");
    rd(A_CAP, 32'hFF, "R12 capability");

    wr(A_ENA, 32'hFFFF_FFFF);
    rd(A_ENA, 32'h8000_009F, "R2 enable mask");
    wr(A_ENA, 32'h0);

    pulse(4'b0001);
    rd(A_STS, 32'h0, "R3 disabled source ignored");

    wr(A_ENA, 32'h0000_0001);
    pulse(4'b0001);
    step();
    chk_irq(1'b0, "R6 global off");
    rd(A_STS, 32'h1, "R3 enabled source sets");

    wr(A_ENA, 32'h8000_0001); step();
    chk_irq(1'b1, "R7 level high asserted");
    wr(A_ENA, 32'h8000_0002); step();
    chk_irq(1'b0, "R7 source mask");
    wr(A_ENA, 32'h8000_0001); step();
    chk_irq(1'b1, "R14 reassert after enable");

    wr(A_STS, 32'h0);
    rd(A_STS, 32'h1, "R4 zero write keeps");
    wr(A_STS, 32'h1); step();
    chk_irq(1'b0, "R7 deassert after clear");
    rd(A_STS, 32'h0, "R4 one write clears");

    evt = 4'b0001;
    wr(A_STS, 32'h1);
    evt = '0;
    rd(A_STS, 32'h1, "R5 set wins");
    wr(A_STS, 32'h1);

    wr(A_ENA, 32'h8000_0087);
    pulse(4'b1111);
    rd(A_STS, 32'h87, "R13 implemented bits");
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, 32'h0, "R4 clear all");

    wr(A_ENA, 32'h8000_0009); step();
    chk_irq(1'b1, "R8 idle high");
    pulse(4'b0001); step();
    chk_irq(1'b0, "R8 active low");
    wr(A_STS, 32'h1); step();
    chk_irq(1'b1, "R8 released");

    wr(A_ENA, 32'h8000_0011); step();
    chk_irq(1'b0, "R9 idle low");
    pulse(4'b0001); step();
    chk_irq(1'b1, "R9 pulse");
    step();
    chk_irq(1'b0, "R9 one cycle");
    pulse(4'b0001); step();
    chk_irq(1'b0, "R9 no repeat");
    step();
    chk_irq(1'b0, "R9 no repeat later");
    wr(A_STS, 32'h1);

    wr(A_ENA, 32'h8000_0019); step();
    chk_irq(1'b1, "R10 idle high");
    pulse(4'b0001); step();
    chk_irq(1'b0, "R10 low pulse");
    step();
    chk_irq(1'b1, "R10 one cycle");
    wr(A_STS, 32'h1);

    wr(A_VEC, 32'hFFFF_FFAB);
    rd(A_VEC, 32'h0000_000B, "R11 vector nibble");
    wr(A_CAP, 32'h0);
    rd(A_CAP, 32'hFF, "R12 write ignored");

    step(); step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule